// File: doc/BRIEF.md
# Cascadable LCD Segment Data Capture Core

This block is the digital core of a dot-matrix LCD column driver. A display controller sends one line of pixel data per row period, either one bit at a time on a single serial pin or four bits at a time on a nibble-wide bus. The core packs the incoming data into a first line register in four-bit groups. A falling edge on a load strobe then copies the whole line into a second register, and that register drives the panel outputs. Each output is a two-bit code that names one of four drive rails. The code depends on the stored pixel bit, the frame alternation input and a blanking input.

Several cores can share one data bus. Each core passes a chain signal to the next one. A core accepts data only while its incoming chain input is LOW. Its outgoing chain signal drops LOW once it has taken a full line, and this enables the next core in the chain. The shift clock and the load strobe are asynchronous pins. They are synchronised into the system clock, and only their falling edges act.

Top module: `seg_capture_core`

## Requirements
- R1: After reset every output code is 2'b01, because the stored line is all zero, the alternation input is LOW and blanking is inactive. The chain output is HIGH.
- R2: When `par_mode` is HIGH, each shift-clock falling edge stores one nibble. Nibble k puts `par_din[0]` on output 4k+1, `par_din[1]` on 4k+2, `par_din[2]` on 4k+3 and `ser_din` on 4k+4. Outputs are numbered from 1, and the first nibble of a line fills outputs 1 to 4.
- R3: When `par_mode` is LOW, each shift-clock falling edge takes one bit from `ser_din`. The n-th bit of a line lands on output n. Bits are committed to the line register in complete groups of four.
- R4: While `blank_n` is HIGH, each output code comes from the alternation input A and the stored bit Q. A=0,Q=1 gives 2'b00 (top rail). A=0,Q=0 gives 2'b01 (upper middle). A=1,Q=0 gives 2'b10 (lower middle). A=1,Q=1 gives 2'b11 (bottom rail).
- R5: While `blank_n` is LOW, every output code is 2'b00, whatever the alternation input and the stored bits are.
- R6: While `chain_in` is HIGH, shift-clock edges leave the line register and the position counters unchanged. The next accepted data starts where the line left off.
- R7: `chain_out` stays HIGH until the core has stored all of its outputs' bits for the current line. It then goes LOW, and later shift-clock edges store nothing in this core.
- R8: The output codes depend on the second register only. That register changes only on a load-strobe falling edge, which copies the first register into it.
- R9: A load-strobe falling edge clears the nibble and bit position counters and returns `chain_out` HIGH, so the next line starts again at output 1.
- R10: Serial bits that do not complete a four-bit group before a load-strobe falling edge are discarded. The outputs in that group keep their previous line's bits.
- R11: With two cores chained (`chain_out` of the first driving `chain_in` of the second), one serial stream of twice the output count fills the first core and then the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| shift_clk | input | 1 | Data shift clock; acts on its falling edge |
| load_strobe | input | 1 | Line transfer strobe; acts on its falling edge |
| par_mode | input | 1 | HIGH selects nibble input, LOW selects serial input |
| ser_din | input | 1 | Serial data, or the top bit of a nibble |
| par_din | input | 3 | Lower three bits of a nibble |
| chain_in | input | 1 | HIGH blocks data capture |
| chain_out | output | 1 | HIGH while this core still accepts data for the line |
| frame_alt | input | 1 | Frame alternation input |
| blank_n | input | 1 | LOW forces every output to the top-rail code |
| level_code | output | 2*NUM_OUTS | Two-bit drive code per output; output n uses bits [2n-1:2n-2] |

## Verification
Two situations are hard to reach from the ports. The first is a serial line cut short in the middle of a four-bit group. The second is the moment the chain hands the bus from one core to the next. The first is reached by loading a line of all ones and then sending 78 zero bits before the next load. The last group must then still show ones, and a following full line must start at output 1. The handoff is exercised by two chained cores fed one 160-bit stream: each core must show its own half after the load, and the second core must report full.

// File: rtl/seg_capture_pkg.sv
`timescale 1ns/1ps
package seg_capture_pkg;

   // bits taken per address of the line register
   localparam int NIB_W = 4;

   typedef enum logic [1:0] {
      LVL_TOP    = 2'b00,
      LVL_MID_HI = 2'b01,
      LVL_MID_LO = 2'b10,
      LVL_BOTTOM = 2'b11
   } level_e;

   // rail choice from alternation phase, stored bit and the blanking input
   function automatic level_e pick_level(input logic alt, input logic q, input logic show);
      level_e r;
      if (!show) begin
         r = LVL_TOP;
      end else begin
         case ({alt, q})
            2'b00:   r = LVL_MID_HI;
            2'b01:   r = LVL_TOP;
            2'b10:   r = LVL_MID_LO;
            default: r = LVL_BOTTOM;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/seg_edge_sync.sv
`timescale 1ns/1ps
module seg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall_pulse
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("seg_edge_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= async_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_in};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign fall_pulse = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/seg_nibble_assembler.sv
`timescale 1ns/1ps
module seg_nibble_assembler #(
   parameter int NUM_NIBS = 20,
   parameter int ADDR_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_fall,
   input  logic              load_fall,
   input  logic              par_mode,
   input  logic              ser_din,
   input  logic [2:0]        par_din,
   input  logic              chain_in,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [3:0]        wr_nib,
   output logic              chain_out,
   output logic [1:0]        bit_cnt_o
);

   localparam logic [ADDR_W-1:0] FULL_CNT = ADDR_W'(NUM_NIBS);

   logic [ADDR_W-1:0] nib_cnt;
   logic [1:0]        bit_cnt;
   logic [2:0]        ser_buf;
   logic              full;
   logic              accept;
   logic              nib_done;

   assign full     = (nib_cnt == FULL_CNT);
   // the load strobe wins over a shift edge in the same cycle
   assign accept   = shift_fall & ~chain_in & ~full & ~load_fall;
   assign nib_done = par_mode | (bit_cnt == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nib_cnt <= '0;
         bit_cnt <= '0;
         ser_buf <= '0;
      end else if (load_fall) begin
         nib_cnt <= '0;
         bit_cnt <= '0;
      end else if (accept) begin
         if (nib_done) begin
            nib_cnt <= nib_cnt + ADDR_W'(1);
            bit_cnt <= '0;
         end else begin
            bit_cnt <= bit_cnt + 2'd1;
            case (bit_cnt)
               2'd0:    ser_buf[0] <= ser_din;
               2'd1:    ser_buf[1] <= ser_din;
               default: ser_buf[2] <= ser_din;
            endcase
         end
      end
   end

   assign wr_en     = accept & nib_done;
   assign wr_addr   = nib_cnt;
   assign wr_nib    = par_mode ? {ser_din, par_din} : {ser_din, ser_buf};
   assign chain_out = ~full;
   assign bit_cnt_o = bit_cnt;

endmodule

// File: rtl/seg_line_latches.sv
`timescale 1ns/1ps
module seg_line_latches
   import seg_capture_pkg::*;
#(
   parameter int NUM_NIBS = 20,
   parameter int ADDR_W   = 7,
   localparam int WIDTH   = NUM_NIBS * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [3:0]        wr_nib,
   input  logic              load_fall,
   output logic [WIDTH-1:0]  shadow,
   output logic [WIDTH-1:0]  line_q
);

   generate
      for (genvar g = 0; g < NUM_NIBS; g++) begin : g_nib
         logic       hit;
         logic [3:0] nib_q;

         assign hit = wr_en && (wr_addr == ADDR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   nib_q <= '0;
            else if (hit) nib_q <= wr_nib;
         end

         assign shadow[g*NIB_W +: NIB_W] = nib_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         line_q <= '0;
      else if (load_fall) line_q <= shadow;
   end

endmodule

// File: rtl/seg_level_encoder.sv
`timescale 1ns/1ps
module seg_level_encoder
   import seg_capture_pkg::*;
#(
   parameter int NUM_OUTS = 80
) (
   input  logic [NUM_OUTS-1:0]   line_q,
   input  logic                  frame_alt,
   input  logic                  blank_n,
   output logic [2*NUM_OUTS-1:0] level_code
);

   generate
      for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
         assign level_code[2*i +: 2] = pick_level(frame_alt, line_q[i], blank_n);
      end
   endgenerate

endmodule

// File: rtl/seg_capture_core.sv
`timescale 1ns/1ps
module seg_capture_core
   import seg_capture_pkg::*;
#(
   parameter int NUM_OUTS    = 80,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  shift_clk,
   input  logic                  load_strobe,
   input  logic                  par_mode,
   input  logic                  ser_din,
   input  logic [2:0]            par_din,
   input  logic                  chain_in,
   output logic                  chain_out,
   input  logic                  frame_alt,
   input  logic                  blank_n,
   output logic [2*NUM_OUTS-1:0] level_code
);

   localparam int NUM_NIBS = NUM_OUTS / NIB_W;

   generate
      if ((NUM_OUTS % NIB_W) != 0 || NUM_OUTS < NIB_W) begin : g_bad_outs
         $error("seg_capture_core: NUM_OUTS must be a nonzero multiple of the nibble width");
      end
      if ((1 << ADDR_W) <= NUM_NIBS) begin : g_bad_addr
         $error("seg_capture_core: ADDR_W too small to count a full line");
      end
   endgenerate

   logic                shift_fall;
   logic                load_fall;
   logic                wr_en;
   logic [ADDR_W-1:0]   wr_addr;
   logic [3:0]          wr_nib;
   logic [1:0]          bit_cnt;
   logic [NUM_OUTS-1:0] shadow;
   logic [NUM_OUTS-1:0] line_q;

   seg_edge_sync #(.STAGES(SYNC_STAGES)) u_shift_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (shift_clk),
      .fall_pulse (shift_fall)
   );

   seg_edge_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (load_strobe),
      .fall_pulse (load_fall)
   );

   seg_nibble_assembler #(.NUM_NIBS(NUM_NIBS), .ADDR_W(ADDR_W)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_fall (shift_fall),
      .load_fall  (load_fall),
      .par_mode   (par_mode),
      .ser_din    (ser_din),
      .par_din    (par_din),
      .chain_in   (chain_in),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_nib     (wr_nib),
      .chain_out  (chain_out),
      .bit_cnt_o  (bit_cnt)
   );

   seg_line_latches #(.NUM_NIBS(NUM_NIBS), .ADDR_W(ADDR_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_nib    (wr_nib),
      .load_fall (load_fall),
      .shadow    (shadow),
      .line_q    (line_q)
   );

   seg_level_encoder #(.NUM_OUTS(NUM_OUTS)) u_enc (
      .line_q     (line_q),
      .frame_alt  (frame_alt),
      .blank_n    (blank_n),
      .level_code (level_code)
   );

endmodule

// File: rtl/seg_capture_core_chk.sv
`timescale 1ns/1ps
module seg_capture_core_chk #(
   parameter int NUM_OUTS = 80,
   parameter int ADDR_W   = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  chain_in,
   input logic                  chain_out,
   input logic                  blank_n,
   input logic [2*NUM_OUTS-1:0] level_code,
   input logic                  shift_fall,
   input logic                  load_fall,
   input logic [ADDR_W-1:0]     wr_addr,
   input logic [1:0]            bit_cnt,
   input logic [NUM_OUTS-1:0]   shadow,
   input logic [NUM_OUTS-1:0]   line_q
);

   // R5
   blank_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |-> (level_code == '0));

   // R7
   chain_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chain_out) |-> $past(shift_fall));

   // R9
   chain_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chain_out) |-> $past(load_fall));

   // R8
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_fall |=> $stable(line_q));

   // R6
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_fall && chain_in && !load_fall) |=> ($stable(wr_addr) && $stable(bit_cnt)));

   // R7
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_out && !load_fall) |=> $stable(shadow));

endmodule

bind seg_capture_core seg_capture_core_chk #(.NUM_OUTS(NUM_OUTS), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chain_in   (chain_in),
   .chain_out  (chain_out),
   .blank_n    (blank_n),
   .level_code (level_code),
   .shift_fall (shift_fall),
   .load_fall  (load_fall),
   .wr_addr    (wr_addr),
   .bit_cnt    (bit_cnt),
   .shadow     (shadow),
   .line_q     (line_q)
);

// File: tb/seg_capture_core_bench.sv
`timescale 1ns/1ps
module seg_capture_core_bench;

   localparam int NUM_OUTS = 80;
   localparam int CW       = 2 * NUM_OUTS;

   // vector fields: [10] nibble mode, [9] alternation, [8] blank_n, [7:0] pattern seed
   localparam logic [10:0] VEC [8] = '{
      {1'b0, 1'b0, 1'b1, 8'h3C},
      {1'b1, 1'b0, 1'b1, 8'hA5},
      {1'b0, 1'b1, 1'b1, 8'h5A},
      {1'b1, 1'b1, 1'b1, 8'h96},
      {1'b1, 1'b0, 1'b0, 8'h71},
      {1'b0, 1'b1, 1'b1, 8'hFF},
      {1'b1, 1'b1, 1'b1, 8'h00},
      {1'b1, 1'b0, 1'b1, 8'hC3}
   };

   logic          clk         = 1'b0;
   logic          rst_n       = 1'b0;
   logic          shift_clk   = 1'b1;
   logic          load_strobe = 1'b1;
   logic          par_mode    = 1'b0;
   logic          ser_din     = 1'b0;
   logic [2:0]    par_din     = 3'b000;
   logic          chain_head  = 1'b0;
   logic          frame_alt   = 1'b0;
   logic          blank_n     = 1'b1;
   logic          chain_mid;
   logic          chain_tail;
   logic [CW-1:0] code_a;
   logic [CW-1:0] code_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   seg_capture_core #(.NUM_OUTS(NUM_OUTS)) u_seg_capture_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .shift_clk   (shift_clk),
      .load_strobe (load_strobe),
      .par_mode    (par_mode),
      .ser_din     (ser_din),
      .par_din     (par_din),
      .chain_in    (chain_head),
      .chain_out   (chain_mid),
      .frame_alt   (frame_alt),
      .blank_n     (blank_n),
      .level_code  (code_a)
   );

   seg_capture_core #(.NUM_OUTS(NUM_OUTS)) u_next (
      .clk         (clk),
      .rst_n       (rst_n),
      .shift_clk   (shift_clk),
      .load_strobe (load_strobe),
      .par_mode    (par_mode),
      .ser_din     (ser_din),
      .par_din     (par_din),
      .chain_in    (chain_mid),
      .chain_out   (chain_tail),
      .frame_alt   (frame_alt),
      .blank_n     (blank_n),
      .level_code  (code_b)
   );

   function automatic logic pat(input logic [7:0] s, input int i);
      logic [15:0] h;
      if (s == 8'hFF) return 1'b1;
      if (s == 8'h00) return 1'b0;
      h = 16'(i) * {8'h00, s} + {s, 8'h00};
      return h[3] ^ h[6] ^ h[9];
   endfunction

   function automatic logic [NUM_OUTS-1:0] line_bits(input logic [7:0] s);
      logic [NUM_OUTS-1:0] r;
      for (int i = 0; i < NUM_OUTS; i++) r[i] = pat(s, i);
      return r;
   endfunction

   function automatic logic [1:0] ref_level(input logic m, input logic q, input logic bn);
      if (!bn) return 2'b00;
      case ({m, q})
         2'b00:   return 2'b01;
         2'b01:   return 2'b00;
         2'b10:   return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   function automatic logic [CW-1:0] ref_codes(input logic [NUM_OUTS-1:0] q, input logic m, input logic bn);
      logic [CW-1:0] r;
      for (int i = 0; i < NUM_OUTS; i++) r[2*i +: 2] = ref_level(m, q[i], bn);
      return r;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe_shift();
      shift_clk = 1'b0;
      tick(4);
      shift_clk = 1'b1;
      tick(4);
   endtask

   task automatic strobe_load();
      tick(1);
      load_strobe = 1'b0;
      tick(4);
      load_strobe = 1'b1;
      tick(4);
   endtask

   task automatic put_bit(input logic b);
      tick(1);
      ser_din = b;
      tick(1);
      strobe_shift();
   endtask

   task automatic put_nibble(input logic [3:0] n);
      tick(1);
      ser_din = n[3];
      par_din = n[2:0];
      tick(1);
      strobe_shift();
   endtask

   task automatic feed(input logic [7:0] s, input logic par, input int first, input int count);
      par_mode = par;
      if (par) begin
         for (int k = first / 4; k < (first + count) / 4; k++)
            put_nibble({pat(s, 4*k+3), pat(s, 4*k+2), pat(s, 4*k+1), pat(s, 4*k)});
      end else begin
         for (int i = first; i < first + count; i++) put_bit(pat(s, i));
      end
   endtask

   task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(3);

      // R1 reset state
      check("R1 reset codes", code_a, ref_codes('0, 1'b0, 1'b1));
      check("R1 reset chain high", CW'(chain_mid), CW'(1'b1));

      // table of lines: R2 nibble mode, R3 serial mode, R4 codes, R5 blanking
      for (int v = 0; v < 8; v++) begin
         logic [10:0] e;
         e = VEC[v];
         frame_alt = e[9];
         blank_n   = e[8];
         feed(e[7:0], e[10], 0, NUM_OUTS);
         check("R7 chain low after full line", CW'(chain_mid), CW'(1'b0));
         strobe_load();
         check(e[8] ? (e[10] ? "R2 R4 nibble line" : "R3 R4 serial line") : "R5 blanked line",
               code_a, ref_codes(line_bits(e[7:0]), e[9], e[8]));
         frame_alt = 1'b0;
         blank_n   = 1'b1;
      end

      // R8 outputs hold while a new line is shifted in
      feed(8'h5A, 1'b0, 0, 40);
      check("R8 outputs held mid line", code_a, ref_codes(line_bits(8'hC3), 1'b0, 1'b1));
      feed(8'h5A, 1'b0, 40, 40);
      check("R7 chain low when full", CW'(chain_mid), CW'(1'b0));
      feed(8'h00, 1'b1, 0, 32);
      strobe_load();
      check("R8 R7 copy on load, extra data ignored", code_a, ref_codes(line_bits(8'h5A), 1'b0, 1'b1));
      check("R9 chain high after load", CW'(chain_mid), CW'(1'b1));

      // R6 chain input high blocks capture
      chain_head = 1'b1;
      feed(8'h3C, 1'b0, 0, NUM_OUTS);
      check("R6 chain stays high while blocked", CW'(chain_mid), CW'(1'b1));
      strobe_load();
      check("R6 line unchanged while blocked", code_a, ref_codes(line_bits(8'h5A), 1'b0, 1'b1));
      chain_head = 1'b0;
      feed(8'h96, 1'b1, 0, NUM_OUTS);
      strobe_load();
      check("R6 next data starts at output 1", code_a, ref_codes(line_bits(8'h96), 1'b0, 1'b1));

      // R10 partial serial group discarded
      feed(8'hFF, 1'b0, 0, NUM_OUTS);
      strobe_load();
      feed(8'h00, 1'b0, 0, NUM_OUTS - 2);
      strobe_load();
      check("R10 partial group dropped", code_a, ref_codes({4'hF, 76'h0}, 1'b0, 1'b1));
      feed(8'hA5, 1'b0, 0, NUM_OUTS);
      strobe_load();
      check("R9 bit counter cleared by load", code_a, ref_codes(line_bits(8'hA5), 1'b0, 1'b1));

      // R11 two chained cores share one stream
      par_mode = 1'b0;
      for (int i = 0; i < 2 * NUM_OUTS; i++)
         put_bit((i < NUM_OUTS) ? pat(8'h3C, i) : pat(8'hC3, i - NUM_OUTS));
      check("R11 second core full", CW'(chain_tail), CW'(1'b0));
      strobe_load();
      check("R11 first core line", code_a, ref_codes(line_bits(8'h3C), 1'b0, 1'b1));
      check("R11 second core line", code_b, ref_codes(line_bits(8'hC3), 1'b0, 1'b1));

      // R5 blanking and R4 alternation applied without a load
      blank_n = 1'b0;
      tick(2);
      check("R5 blank forces top rail", code_a, ref_codes(line_bits(8'h3C), 1'b1, 1'b0));
      blank_n   = 1'b1;
      frame_alt = 1'b1;
      tick(2);
      check("R4 alternation applied live", code_a, ref_codes(line_bits(8'h3C), 1'b1, 1'b1));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule